// File: doc/BRIEF.md
# Lamp Start and Restart Sequencer

This block sequences the start of a fluorescent lamp from a single digital timing ramp. A register holds an unsigned code that stands for the voltage on a timing capacitor, with one LSB equal to 10 mV. On each tick of a divided timebase the code rises by a programmable charge step or falls by a programmable discharge step. Crossings of fixed thresholds move the sequencer through five phases: initialise, filament preheat, dimming lockout, running and lamp-out inhibit.

The phase drives three control flags. The first makes the oscillator use its fixed high preheat frequency. The second makes the oscillator disregard the dimming feedback loop. The third shuts off the inverter. A lamp-fault flag stops charging and inhibits the inverter. Once the ramp has bled down to the recovery level, a new start attempt begins, and it passes through the same phases in the same order as the first start. A supply-supervisor enable returns the block to its initial state whenever it drops.

Top module: `lamp_start_seq`

## Requirements
- R1: Out of reset, and whenever the block is in the initialise phase, phase is 0, inv_inhibit is 1, dim_ignore is 1 and preheat_sel is 0. The ramp holds the code 70, which stands for 0.7 V.
- R2: When supply_ok is low, the phase is 0 in the next cycle whatever the current phase, and the ramp is reloaded with 70.
- R3: From the initialise phase with supply_ok high, the block enters preheat (phase 1) in the next cycle. While in preheat, preheat_sel is 1, dim_ignore is 1 and inv_inhibit is 0.
- R4: Preheat ends, and lockout (phase 2) begins, in the cycle after the ramp reaches 480 (4.8 V) or more. During lockout, dim_ignore is 1 and preheat_sel and inv_inhibit are 0.
- R5: Lockout ends, and run (phase 3) begins, in the cycle after the ramp reaches 680 (6.8 V) or more. During run, all three flags are 0.
- R6: In preheat, lockout and run the ramp rises by chg_step on each tick. It never rises above 750 (7.5 V).
- R7: lamp_fault high in preheat, lockout or run gives the inhibit phase (phase 4) in the next cycle. In that phase inv_inhibit is 1, dim_ignore is 1 and preheat_sel is 0. The flag has no effect in the initialise and inhibit phases.
- R8: In the inhibit phase the ramp falls by dis_step on each tick, with a floor of 0, and never rises. In the cycle after the ramp drops to 120 (1.2 V) or below, preheat begins again. The phases after that follow the order preheat, lockout, run.
- R9: A tick occurs once every TICK_DIV clock cycles. The step inputs are sampled only on ticks.
- R10: The phase codes are 0 = initialise, 1 = preheat, 2 = lockout, 3 = run, 4 = inhibit. All outputs are registered and change on the same edge as the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Enable from the supply supervisor |
| lamp_fault | input | 1 | Lamp-out / failed-strike flag |
| chg_step | input | STEP_W | Ramp increase per tick |
| dis_step | input | STEP_W | Ramp decrease per tick |
| phase | output | 3 | Current phase code |
| preheat_sel | output | 1 | Select fixed preheat frequency |
| dim_ignore | output | 1 | Oscillator ignores dimming feedback |
| inv_inhibit | output | 1 | Inverter shut off |

## Verification
The sequence is run with two charge steps, 10 and 25. Because the ramp is not visible at the ports, the time spent in each phase serves as a readout of the ramp level at the start and end of that phase. Those dwell times tell apart the 0.7 V initial load, the 1.2 V restart level and the 7.5 V clamp. A long stay in run followed by a fault separates a clamped ramp from one that keeps climbing. Fault pulses in preheat, in run, in inhibit and while idle check that the retry loop restarts in the right order and that the flag is ignored where it should be. A supply drop in the middle of run checks the return to the initial state.

// File: rtl/lss_pkg.sv
// Package: shared phase encoding for the lamp start sequencer.
// Assumes: a 3-bit phase code seen directly at the top-level port.
package lss_pkg;
    typedef enum logic [2:0] {
        PH_INIT    = 3'd0,
        PH_PREHEAT = 3'd1,
        PH_LOCKOUT = 3'd2,
        PH_RUN     = 3'd3,
        PH_INHIBIT = 3'd4
    } phase_t;
endpackage

// File: rtl/lss_tick_gen.sv
// Module: lss_tick_gen
// Produces a one-cycle tick once every TICK_DIV clocks from a free-running
// counter. Assumes TICK_DIV >= 1; a divide of one gives a tick on every cycle
// after reset.
module lss_tick_gen #(
    parameter int unsigned TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_every
            logic run_q;
            // Purpose: hold the tick low only while in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) run_q <= 1'b0;
                else        run_q <= 1'b1;
            end
            assign tick = run_q;
        end else begin : g_div
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
            logic [CNT_W-1:0] cnt;
            // Purpose: count modulo TICK_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R9
        end
    endgenerate
endmodule

// File: rtl/lss_ramp.sv
// Module: lss_ramp
// Holds the timing-ramp code. On a tick it adds the charge step (saturating
// at LVL_CLAMP) or takes away the discharge step (floored at zero). Assumes
// that charge and discharge are never requested together and that load
// overrides both.
module lss_ramp #(
    parameter int unsigned CODE_W    = 12,
    parameter int unsigned STEP_W    = 8,
    parameter int unsigned LVL_INIT  = 70,
    parameter int unsigned LVL_CLAMP = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic              charge,
    input  logic              discharge,
    input  logic [STEP_W-1:0] chg_step,
    input  logic [STEP_W-1:0] dis_step,
    output logic [CODE_W-1:0] value
);
    localparam logic [CODE_W-1:0] INIT_C  = CODE_W'(LVL_INIT);
    localparam logic [CODE_W:0]   CLAMP_W = (CODE_W+1)'(LVL_CLAMP);

    logic [CODE_W:0]   up_sum;
    logic [CODE_W-1:0] up_val;
    logic [CODE_W-1:0] dn_step;
    logic [CODE_W-1:0] dn_val;

    // Purpose: the saturating charge result and the floored discharge result.
    always_comb begin
        up_sum  = (CODE_W+1)'(value) + (CODE_W+1)'(chg_step);
        up_val  = (up_sum > CLAMP_W) ? CLAMP_W[CODE_W-1:0] : up_sum[CODE_W-1:0];
        dn_step = CODE_W'(dis_step);
        dn_val  = (value > dn_step) ? (value - dn_step) : '0;
    end

    // Purpose: the ramp register, with load taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                 value <= INIT_C;
        else if (load)              value <= INIT_C;
        else if (tick && charge)    value <= up_val;
        else if (tick && discharge) value <= dn_val;
    end

    AST_RAMP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        value <= CLAMP_W[CODE_W-1:0]); // R6
    AST_DISCHARGE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (discharge && !load) |=> (value <= $past(value))); // R8
    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(value)); // R9
endmodule

// File: rtl/lss_phase_fsm.sv
// Module: lss_phase_fsm
// Phase sequencer: it compares the ramp code against the preheat-end,
// lockout-end and recovery thresholds and reacts to the lamp fault and the
// supply enable. Every output is registered from the next-state value, so
// the flags change on the same edge as the phase. Assumes the ramp value
// is the registered output of lss_ramp.
module lss_phase_fsm
    import lss_pkg::*;
#(
    parameter int unsigned CODE_W       = 12,
    parameter int unsigned LVL_PRE_END  = 480,
    parameter int unsigned LVL_LOCK_END = 680,
    parameter int unsigned LVL_RECOVER  = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              lamp_fault,
    input  logic [CODE_W-1:0] value,
    output phase_t            ph_q,
    output logic              preheat_sel,
    output logic              dim_ignore,
    output logic              inv_inhibit,
    output logic              charge_en,
    output logic              discharge_en
);
    localparam logic [CODE_W-1:0] PRE_C  = CODE_W'(LVL_PRE_END);
    localparam logic [CODE_W-1:0] LOCK_C = CODE_W'(LVL_LOCK_END);
    localparam logic [CODE_W-1:0] REC_C  = CODE_W'(LVL_RECOVER);

    phase_t ph_d;

    // Purpose: next-phase selection, with the supply enable first, then the fault, then the thresholds.
    always_comb begin
        ph_d = ph_q;
        if (!supply_ok) begin
            ph_d = PH_INIT;
        end else begin
            unique case (ph_q)
                PH_INIT:    ph_d = PH_PREHEAT;
                PH_PREHEAT: if (lamp_fault)        ph_d = PH_INHIBIT;
                            else if (value >= PRE_C)  ph_d = PH_LOCKOUT;
                PH_LOCKOUT: if (lamp_fault)        ph_d = PH_INHIBIT;
                            else if (value >= LOCK_C) ph_d = PH_RUN;
                PH_RUN:     if (lamp_fault)        ph_d = PH_INHIBIT;
                PH_INHIBIT: if (value <= REC_C)    ph_d = PH_PREHEAT;
                default:    ph_d = PH_INIT;
            endcase
        end
    end

    // Purpose: the phase register and the output flags, all taken from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q        <= PH_INIT;
            preheat_sel <= 1'b0;
            dim_ignore  <= 1'b1;
            inv_inhibit <= 1'b1;
        end else begin
            ph_q        <= ph_d;
            preheat_sel <= (ph_d == PH_PREHEAT);
            dim_ignore  <= (ph_d != PH_RUN);
            inv_inhibit <= (ph_d == PH_INIT) || (ph_d == PH_INHIBIT);
        end
    end

    // Purpose: the ramp direction follows the current phase.
    always_comb begin
        charge_en    = (ph_q == PH_PREHEAT) || (ph_q == PH_LOCKOUT) || (ph_q == PH_RUN);
        discharge_en = (ph_q == PH_INHIBIT);
    end

    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (ph_q == PH_INIT)); // R2
    AST_FAULT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && lamp_fault && charge_en) |=> (ph_q == PH_INHIBIT)); // R7
    AST_PREHEAT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !lamp_fault && ph_q == PH_PREHEAT && value >= PRE_C)
        |=> (ph_q == PH_LOCKOUT)); // R4
    AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LOCKOUT && $past(ph_q) != PH_LOCKOUT)
        |-> ($past(ph_q) == PH_PREHEAT)); // R4
    AST_RUN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN && $past(ph_q) != PH_RUN)
        |-> ($past(ph_q) == PH_LOCKOUT)); // R5
    AST_FLAG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (preheat_sel == (ph_q == PH_PREHEAT)) && (dim_ignore == (ph_q != PH_RUN))); // R10
endmodule

// File: rtl/lamp_start_seq.sv
// Module: lamp_start_seq (top)
// Lamp start and restart sequencer built from a tick divider, a timing ramp
// and a phase FSM. The ramp is reloaded with the initial level whenever the
// supply enable is low or the block is in the initialise phase. Assumes the
// step inputs are quasi-static.
module lamp_start_seq
    import lss_pkg::*;
#(
    parameter int unsigned CODE_W       = 12,
    parameter int unsigned STEP_W       = 8,
    parameter int unsigned TICK_DIV     = 4,
    parameter int unsigned LVL_INIT     = 70,
    parameter int unsigned LVL_RECOVER  = 120,
    parameter int unsigned LVL_PRE_END  = 480,
    parameter int unsigned LVL_LOCK_END = 680,
    parameter int unsigned LVL_CLAMP    = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              lamp_fault,
    input  logic [STEP_W-1:0] chg_step,
    input  logic [STEP_W-1:0] dis_step,
    output logic [2:0]        phase,
    output logic              preheat_sel,
    output logic              dim_ignore,
    output logic              inv_inhibit
);
    logic              tick;
    logic [CODE_W-1:0] ramp_val;
    logic              charge_en;
    logic              discharge_en;
    logic              ramp_load;
    phase_t            ph_q;

    lss_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Purpose: reload the ramp while the block is idle or the supply is absent.
    assign ramp_load = !supply_ok || (ph_q == PH_INIT);

    lss_ramp #(
        .CODE_W    (CODE_W),
        .STEP_W    (STEP_W),
        .LVL_INIT  (LVL_INIT),
        .LVL_CLAMP (LVL_CLAMP)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (ramp_load),
        .charge    (charge_en),
        .discharge (discharge_en),
        .chg_step  (chg_step),
        .dis_step  (dis_step),
        .value     (ramp_val)
    );

    lss_phase_fsm #(
        .CODE_W       (CODE_W),
        .LVL_PRE_END  (LVL_PRE_END),
        .LVL_LOCK_END (LVL_LOCK_END),
        .LVL_RECOVER  (LVL_RECOVER)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .lamp_fault   (lamp_fault),
        .value        (ramp_val),
        .ph_q         (ph_q),
        .preheat_sel  (preheat_sel),
        .dim_ignore   (dim_ignore),
        .inv_inhibit  (inv_inhibit),
        .charge_en    (charge_en),
        .discharge_en (discharge_en)
    );

    assign phase = ph_q;

    AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_INIT) |=> (ph_q == PH_INIT || ramp_val == CODE_W'(LVL_INIT))); // R1
    AST_INHIBIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_INHIBIT) |-> (inv_inhibit && !preheat_sel)); // R7
endmodule

// File: tb/tb_lamp_start_seq.sv
module tb_lamp_start_seq;
    localparam int unsigned D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       lamp_fault = 1'b0;
    logic [7:0] chg_step = 8'd10;
    logic [7:0] dis_step = 8'd30;
    logic [2:0] phase;
    logic       preheat_sel, dim_ignore, inv_inhibit;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0] ph;
        int         lo;
        int         hi;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    lamp_start_seq dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lamp_fault(lamp_fault),
        .chg_step(chg_step), .dis_step(dis_step), .phase(phase),
        .preheat_sel(preheat_sel), .dim_ignore(dim_ignore), .inv_inhibit(inv_inhibit)
    );

    function automatic int ticks_up(int from, int to, int step);
        return (to - from + step - 1) / step;
    endfunction
    function automatic int ticks_dn(int from, int to, int step);
        return (from - to + step - 1) / step;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Driver side: push an expected phase with dwell bounds in cycles (hi = 0: any dwell)
    task automatic push_exp(input logic [2:0] ph, input int n_ticks, input string req);
        exp_t e;
        e.ph  = ph;
        e.lo  = (n_ticks > 0) ? (n_ticks - 1) * D + 2 : 0;
        e.hi  = (n_ticks > 0) ? n_ticks * D + 1 : 0;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_phase(input logic [2:0] p);
        while (phase !== p) @(negedge clk);
    endtask

    task automatic pulse_fault();
        @(negedge clk);
        lamp_fault = 1'b1;
        @(negedge clk);
        lamp_fault = 1'b0;
    endtask

    // Monitor: pop the expected item on each phase change, check the flags and the previous dwell
    logic [2:0] prev_ph = 3'd0;
    int dwell = 0;
    int cur_lo = 0, cur_hi = 0;
    string cur_req = "R1";
    bit mon_on = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (phase !== prev_ph) begin
                if (cur_hi != 0)
                    check(dwell >= cur_lo && dwell <= cur_hi, {cur_req, " dwell"}, dwell, cur_lo);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected phase", int'(phase), int'(prev_ph));
                    cur_hi = 0;
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(phase === e.ph, {e.req, " phase order"}, int'(phase), int'(e.ph));
                    cur_lo = e.lo; cur_hi = e.hi; cur_req = e.req;
                end
                // R10 flag encoding: preheat_sel only in 1, dim_ignore except in 3, inhibit in 0 and 4
                check({preheat_sel, dim_ignore, inv_inhibit} ===
                      {phase == 3'd1, phase != 3'd3, (phase == 3'd0) || (phase == 3'd4)},
                      "R10 flags", int'({preheat_sel, dim_ignore, inv_inhibit}), int'(phase));
                prev_ph = phase;
                dwell = 1;
            end else begin
                dwell++;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        int pre_n, lock_n, inh_n, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(phase === 3'd0 && inv_inhibit && dim_ignore && !preheat_sel, "R1 reset",
              int'({phase, preheat_sel, dim_ignore, inv_inhibit}), 3);
        mon_on = 1'b1;

        // First start with step 10 from 0.7 V, then a clamp test in run (R3 R4 R5 R6)
        pre_n  = ticks_up(70, 480, 10);
        lock_n = ticks_up(70 + pre_n * 10, 680, 10);
        inh_n  = ticks_dn(750, 120, 30);
        push_exp(3'd1, pre_n, "R3");
        push_exp(3'd2, lock_n, "R4");
        push_exp(3'd3, 0, "R5");
        push_exp(3'd4, inh_n, "R6");          // dwell reveals the ramp clamped at 750
        v = 750 - inh_n * 30;
        pre_n  = ticks_up(v, 480, 10);
        push_exp(3'd1, pre_n, "R8");          // restart from the 1.2 V level
        push_exp(3'd2, ticks_up(v + pre_n * 10, 680, 10), "R8");
        push_exp(3'd3, 0, "R8");
        supply_ok = 1'b1;
        wait_phase(3'd3);
        repeat (200) @(negedge clk);
        pulse_fault();                        // R7 fault in run
        wait_phase(3'd4);
        repeat (10) @(negedge clk);
        pulse_fault();                        // R7 ignored in inhibit (dwell unchanged)
        wait_phase(3'd3);
        repeat (5) @(negedge clk);

        // Supply drop in run (R2), fault ignored while idle (R7)
        push_exp(3'd0, 0, "R2");
        supply_ok = 1'b0;
        @(negedge clk);
        check(phase === 3'd0 && inv_inhibit, "R2 supply drop", int'(phase), 0);
        lamp_fault = 1'b1;
        repeat (20) @(negedge clk);
        lamp_fault = 1'b0;
        check(phase === 3'd0, "R7 fault ignored in init", int'(phase), 0);
        check(inv_inhibit === 1'b1, "R1 inhibit in init", int'(inv_inhibit), 1);

        // Second start with step 25 from the reloaded 0.7 V (R1 R9)
        chg_step = 8'd25;
        pre_n  = ticks_up(70, 480, 25);
        lock_n = ticks_up(70 + pre_n * 25, 680, 25);
        push_exp(3'd1, pre_n, "R1");
        push_exp(3'd2, lock_n, "R9");
        push_exp(3'd3, 0, "R5");
        push_exp(3'd4, ticks_dn(750, 120, 30), "R6");
        push_exp(3'd1, 0, "R7");              // preheat interrupted by a fault
        push_exp(3'd4, 0, "R7");
        push_exp(3'd1, 0, "R8");
        push_exp(3'd2, 0, "R8");
        push_exp(3'd3, 0, "R8");
        supply_ok = 1'b1;
        wait_phase(3'd3);
        repeat (100) @(negedge clk);
        pulse_fault();
        wait_phase(3'd4);
        wait_phase(3'd1);
        repeat (20) @(negedge clk);
        pulse_fault();                        // R7 fault during preheat
        wait_phase(3'd4);
        wait_phase(3'd3);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8 all phases seen", exp_q.size(), 0);
        check(phase === 3'd3 && !dim_ignore, "R5 run flags", int'(phase), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule